// File: doc/BRIEF.md
# Port 80h Write Snooper for a 32-bit PCI Bus

A listen-only monitor that sits on a 32-bit PCI bus and records every byte written to I/O port 80h, the port where system firmware posts its progress codes during power-on. All bus lines are inputs to the block; it never claims, answers or loads a transaction. Each rising edge of the bus clock samples FRAME, IRDY, the multiplexed address/data lines and the command/byte-enable lines.

After reset the monitor idles until it sees FRAME fall. On that edge it decodes the command and the full address. When both match an I/O write to 80h, it looks once more at the bus on the following edge: if byte lane 0 is enabled, the low data byte is taken as a new code. Whether or not the transaction matched, the monitor then waits for the bus to go idle before it looks for the next start. Captured codes land in a two-entry history (newest and the one before it) that can drive a pair of display digits, and each capture is marked by a one-cycle strobe.

Top module: `pci_port80_snooper`

## Requirements
- R1: While rst_n is low, cap_strobe is 0 and both newest_byte and older_byte are 8'h00 from the next clock edge on.
- R2: A transaction start is an edge with frame_n low where the previous edge had frame_n high; the reset treats the previous edge as low, so a FRAME already asserted when reset is released is never taken as a start.
- R3: A start is a match only if cbe_n equals 4'b0011 (I/O write) and ad equals 32'h0000_0080 on the start edge; any other command or address leads to no capture.
- R4: On the edge right after a matching start, if cbe_n[0] is 0, ad[7:0] is captured: in the following cycle cap_strobe is 1 and newest_byte holds that byte.
- R5: If cbe_n[0] is 1 on that edge, nothing is captured: cap_strobe stays 0 and both stored bytes keep their values.
- R6: After any start, no new start is recognised until an edge where frame_n and irdy_n are both 1; a FRAME re-assertion before that edge is ignored.
- R7: On each capture the previous newest_byte moves to older_byte and the previous older_byte is dropped.
- R8: Only the first data phase after the address phase is looked at; later data phases of the same transaction never cause a capture.
- R9: cap_strobe is high for exactly one cycle per captured byte, and back-to-back matching writes each give their own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Bus FRAME, active low |
| irdy_n | input | 1 | Bus initiator-ready, active low |
| ad | input | 32 | Multiplexed address/data lines |
| cbe_n | input | 4 | Command (address phase) / byte enables (data phase), active low |
| cap_strobe | output | 1 | One-cycle pulse for each captured byte |
| newest_byte | output | 8 | Most recently captured code |
| older_byte | output | 8 | Code captured before the newest one |

## Verification
The bench builds the block with its default parameters: the 32-bit bus, port address 80h, I/O-write command 0011 and a two-deep history. With these values the exact-address decode is reachable from both sides (neighbouring address 81h and an address that differs only in high bits), as are the shift from newest to older over three successive captures and the case where a FRAME held low across reset release must not be read as a start. Burst writes, disabled lane 0, wrong commands and early FRAME re-assertion before the bus goes idle all run against a per-cycle reference model.

// File: rtl/pci_snoop_pkg.sv
// Package: shared types and widths for the port-80h snooper.
// Assumes: byte-wide captured codes.
package pci_snoop_pkg;

    localparam int BYTE_W = 8;

    // Phase of the bus as seen by the monitor.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // waiting for FRAME to fall
        PH_DATA  = 2'd1,   // edge after a matching address phase
        PH_DRAIN = 2'd2    // waiting for the bus to go idle
    } snoop_phase_e;

endpackage

// File: rtl/snoop_start_detect.sv
// Module: snoop_start_detect
// Finds the address phase of each transaction (FRAME falling) and decodes
// whether it is the watched I/O write. Assumes inputs are already synchronous
// to clk. The previous-FRAME state resets to "asserted" so that a transaction
// in flight at reset release is not mistaken for a new one.
module snoop_start_detect #(
    parameter int               AD_W       = 32,
    parameter int               CBE_W      = 4,
    parameter logic [AD_W-1:0]  MATCH_ADDR = 32'h0000_0080,
    parameter logic [CBE_W-1:0] MATCH_CMD  = 4'b0011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe_n,
    output logic             start,
    output logic             hit
);

    logic frame_was_low;
    logic addr_eq;
    logic cmd_eq;

    // Remember FRAME level from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_was_low <= 1'b1;
        else        frame_was_low <= ~frame_n;
    end

    // Decode falling FRAME and the command/address of that phase.
    always_comb begin
        start   = ~frame_n & ~frame_was_low;
        addr_eq = (ad == MATCH_ADDR);
        cmd_eq  = (cbe_n == MATCH_CMD);
        hit     = start & addr_eq & cmd_eq;
    end

endmodule

// File: rtl/snoop_phase_fsm.sv
// Module: snoop_phase_fsm
// Tracks where the monitor is within a transaction and raises a take pulse
// on the single edge where the port byte may be captured. Assumes start/hit
// come from snoop_start_detect on the same edge. Ignores TRDY and STOP.
module snoop_phase_fsm
    import pci_snoop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hit,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic lane0_n,
    output logic take
);

    snoop_phase_e phase_q;
    snoop_phase_e phase_d;
    logic         bus_idle;

    // Next-phase selection.
    always_comb begin
        bus_idle = frame_n & irdy_n;
        phase_d  = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (start) phase_d = hit ? PH_DATA : PH_DRAIN;
            PH_DATA:  phase_d = bus_idle ? PH_IDLE : PH_DRAIN;
            PH_DRAIN: if (bus_idle) phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Capture is allowed only in the first data phase with lane 0 on.
    always_comb begin
        take = (phase_q == PH_DATA) & ~lane0_n;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

endmodule

// File: rtl/snoop_byte_history.sv
// Module: snoop_byte_history
// Shift register of the last DEPTH captured bytes, slot 0 newest, plus a
// one-cycle strobe per capture. Assumes take is a single-edge request.
module snoop_byte_history #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [W-1:0]       din,
    output logic               strobe,
    output logic [DEPTH*W-1:0] slots
);

    logic [W-1:0] slot_q [DEPTH];

    // Strobe follows each accepted capture by one register.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= take;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == 0) begin : g_head
            // Newest slot loads the fresh byte.
            always_ff @(posedge clk) begin
                if (!rst_n)    slot_q[i] <= '0;
                else if (take) slot_q[i] <= din;
            end
        end else begin : g_tail
            // Older slots take their younger neighbour's content.
            always_ff @(posedge clk) begin
                if (!rst_n)    slot_q[i] <= '0;
                else if (take) slot_q[i] <= slot_q[i-1];
            end
        end
        assign slots[i*W +: W] = slot_q[i];
    end

endmodule

// File: rtl/pci_port80_snooper.sv
// Module: pci_port80_snooper (top)
// Passive monitor of a 32-bit PCI bus that records byte writes to I/O port
// 80h. Every port is an input except the capture outputs; no bus line is ever
// driven. Assumes the bus signals are synchronous to clk.
module pci_port80_snooper
    import pci_snoop_pkg::*;
#(
    parameter int               AD_W      = 32,
    parameter int               CBE_W     = 4,
    parameter logic [AD_W-1:0]  PORT_ADDR = 32'h0000_0080,
    parameter logic [CBE_W-1:0] IOWR_CMD  = 4'b0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [AD_W-1:0]   ad,
    input  logic [CBE_W-1:0]  cbe_n,
    output logic              cap_strobe,
    output logic [BYTE_W-1:0] newest_byte,
    output logic [BYTE_W-1:0] older_byte
);

    localparam int HIST_DEPTH = 2;

    logic                         start;
    logic                         hit;
    logic                         take;
    logic [HIST_DEPTH*BYTE_W-1:0] slots;

    snoop_start_detect #(
        .AD_W       (AD_W),
        .CBE_W      (CBE_W),
        .MATCH_ADDR (PORT_ADDR),
        .MATCH_CMD  (IOWR_CMD)
    ) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .ad      (ad),
        .cbe_n   (cbe_n),
        .start   (start),
        .hit     (hit)
    );

    snoop_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .hit     (hit),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .lane0_n (cbe_n[0]),
        .take    (take)
    );

    snoop_byte_history #(
        .DEPTH (HIST_DEPTH),
        .W     (BYTE_W)
    ) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .din    (ad[BYTE_W-1:0]),
        .strobe (cap_strobe),
        .slots  (slots)
    );

    assign newest_byte = slots[0 +: BYTE_W];
    assign older_byte  = slots[BYTE_W +: BYTE_W];

endmodule

// File: rtl/pci_port80_snooper_checker.sv
// Module: pci_port80_snooper_checker
// Temporal checks on the snooper's ports, bound to every instance of the top.
module pci_port80_snooper_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_n,
    input logic        irdy_n,
    input logic [31:0] ad,
    input logic [3:0]  cbe_n,
    input logic        cap_strobe,
    input logic [7:0]  newest_byte,
    input logic [7:0]  older_byte
);

    // R1: reset clears the strobe and both stored codes.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!cap_strobe && newest_byte == 8'h00 && older_byte == 8'h00));

    // R2: a capture traces back to an edge with FRAME high before the start.
    assert_start_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |-> ($past(frame_n, 3) && !$past(frame_n, 2)));

    // R3: the address phase two edges back carried the watched write.
    assert_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |-> ($past(cbe_n, 2) == 4'b0011 && $past(ad, 2) == 32'h0000_0080));

    // R4: captured byte is the low data byte with lane 0 enabled.
    assert_capture_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |-> (newest_byte == $past(ad[7:0]) && !$past(cbe_n[0])));

    // R5: without a strobe the stored codes do not move.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_strobe |-> ($stable(newest_byte) && $stable(older_byte)));

    // R7: the previous newest code becomes the older one.
    assert_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |-> (older_byte == $past(newest_byte)));

    // R9: the strobe never lasts two cycles.
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |=> !cap_strobe);

endmodule

bind pci_port80_snooper pci_port80_snooper_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .ad          (ad),
    .cbe_n       (cbe_n),
    .cap_strobe  (cap_strobe),
    .newest_byte (newest_byte),
    .older_byte  (older_byte)
);

// File: tb/pci_port80_snooper_test.sv
// Bench: drives bus transactions, compares against a behavioural model on
// every clock and runs scenario checks tagged by requirement.
module pci_port80_snooper_test;

    logic        clk     = 1'b0;
    logic        rst_n   = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n  = 1'b1;
    logic [31:0] ad      = 32'h0;
    logic [3:0]  cbe_n   = 4'hF;
    logic        cap_strobe;
    logic [7:0]  newest_byte;
    logic [7:0]  older_byte;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pci_port80_snooper uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_n     (frame_n),
        .irdy_n      (irdy_n),
        .ad          (ad),
        .cbe_n       (cbe_n),
        .cap_strobe  (cap_strobe),
        .newest_byte (newest_byte),
        .older_byte  (older_byte)
    );

    // Reference model: phase as integer, history as a queue.
    int         m_phase = 0;
    bit         m_prev_low = 1;
    bit         m_stb = 0;
    logic [7:0] m_hist[$] = '{8'h00, 8'h00};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_prev_low = 1;
            m_stb = 0;
            m_hist = '{8'h00, 8'h00};
        end else begin
            m_stb = 0;
            if (m_phase == 0) begin
                if (frame_n == 1'b0 && !m_prev_low)
                    m_phase = (cbe_n == 4'd3 && ad == 32'd128) ? 1 : 2;
            end else if (m_phase == 1) begin
                if (cbe_n[0] == 1'b0) begin
                    m_hist.push_front(ad[7:0]);
                    void'(m_hist.pop_back());
                    m_stb = 1;
                end
                m_phase = (frame_n && irdy_n) ? 0 : 2;
            end else begin
                if (frame_n && irdy_n) m_phase = 0;
            end
            m_prev_low = (frame_n == 1'b0);
        end
    end

    // Per-cycle comparison against the model (R4, R7, R9) and strobe count.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (cap_strobe !== m_stb || newest_byte !== m_hist[0] || older_byte !== m_hist[1]) begin
                errors++;
                $display("FAIL R4/R7/R9 model: got stb=%0b new=%h old=%h exp stb=%0b new=%h old=%h",
                         cap_strobe, newest_byte, older_byte, m_stb, m_hist[0], m_hist[1]);
            end
            if (cap_strobe === 1'b1) strobes++;
        end
    end

    task automatic check_state(input string tag, input int exp_strobes,
                               input logic [7:0] exp_new, input logic [7:0] exp_old);
        @(negedge clk); #1;
        checks++;
        if (strobes != exp_strobes || newest_byte !== exp_new || older_byte !== exp_old) begin
            errors++;
            $display("FAIL %s: got strobes=%0d new=%h old=%h exp strobes=%0d new=%h old=%h",
                     tag, strobes, newest_byte, older_byte, exp_strobes, exp_new, exp_old);
        end
    endtask

    // One transaction: address phase then nph data phases, then idle.
    task automatic bus_txn(input logic [3:0] cmd, input logic [31:0] addr,
                           input logic [7:0] data, input bit lane0_on, input int nph);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; cbe_n = cmd; ad = addr;
        for (int i = 0; i < nph; i++) begin
            @(negedge clk);
            frame_n = (i == nph - 1);
            irdy_n  = 1'b0;
            ad      = {24'hDEAD_BE, data + 8'(i * 17)};
            cbe_n   = {3'b000, ~lane0_on};
        end
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad = 32'h5555_AAAA;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got no finish exp finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_state("R1 reset", 0, 8'h00, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: matching write with lane 0 on
        bus_txn(4'b0011, 32'h0000_0080, 8'hA5, 1, 1);
        check_state("R4 capture", 1, 8'hA5, 8'h00);

        // R7: second write shifts history
        bus_txn(4'b0011, 32'h0000_0080, 8'h3C, 1, 1);
        check_state("R7 shift", 2, 8'h3C, 8'hA5);

        // R5: lane 0 disabled
        bus_txn(4'b0011, 32'h0000_0080, 8'h11, 0, 1);
        check_state("R5 lane off", 2, 8'h3C, 8'hA5);

        // R3: wrong command, wrong addresses
        bus_txn(4'b0010, 32'h0000_0080, 8'h22, 1, 1);
        check_state("R3 read cmd", 2, 8'h3C, 8'hA5);
        bus_txn(4'b0011, 32'h0000_0081, 8'h33, 1, 1);
        check_state("R3 addr 81h", 2, 8'h3C, 8'hA5);
        bus_txn(4'b0011, 32'h1000_0080, 8'h44, 1, 1);
        check_state("R3 high bits", 2, 8'h3C, 8'hA5);

        // R8: burst, only first data phase counts
        bus_txn(4'b0011, 32'h0000_0080, 8'h60, 1, 4);
        check_state("R8 burst", 3, 8'h60, 8'h3C);

        // R6: FRAME re-asserted before bus goes idle is ignored
        @(negedge clk);
        frame_n = 1'b0; cbe_n = 4'b0010; ad = 32'h0000_0040;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'b0000; ad = 32'h0;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b0; cbe_n = 4'b0011; ad = 32'h0000_0080;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'b0000; ad = 32'h0000_0077;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
        check_state("R6 early frame", 3, 8'h60, 8'h3C);

        // R9: back-to-back matching writes
        bus_txn(4'b0011, 32'h0000_0080, 8'h81, 1, 1);
        bus_txn(4'b0011, 32'h0000_0080, 8'h82, 1, 1);
        check_state("R9 back to back", 5, 8'h82, 8'h81);

        // R2: FRAME held low across reset release is not a start
        @(negedge clk);
        rst_n = 1'b0;
        frame_n = 1'b0; irdy_n = 1'b1; cbe_n = 4'b0011; ad = 32'h0000_0080;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'b0000; ad = 32'h0000_0099;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
        check_state("R2 frame at reset", 5, 8'h00, 8'h00);

        // R2: a clean start afterwards still works
        bus_txn(4'b0011, 32'h0000_0080, 8'hC7, 1, 1);
        check_state("R2 after reset", 6, 8'hC7, 8'h00);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule